// File: doc/BRIEF.md
# Reset Supervisor with Manual and Pin Reset

This block produces a system reset from three causes: a supply-good flag from an analog comparator, a pushbutton input that is active low, and a shared open-drain reset pin that other devices may also pull low. All three inputs are asynchronous. Each one passes through a two-flop synchroniser before any filtering or edge detection.

The supply flag and the pushbutton act as levels. Reset is held for as long as either one reports a fault. After the last fault clears, reset stays asserted for a further hold time. A falling edge on the reset pin is treated as a single event. It starts the same hold time even if the external pulse was much shorter. Low pulses on the supply flag and on the pushbutton are ignored unless they last a set number of consecutive cycles.

The block drives the pin through a drive-enable. While `rst_drive_o` is 1, the pad pulls the pin low. The block's own drive is kept from being seen as an external edge. Every time is a count of clock cycles, worked out from the clock frequency in kHz by parameters.

Top module: `rstgen_supervisor`

## Requirements
- R1: While `arst_n` is low, and afterwards for as long as `supply_ok_i` is low, `rst_drive_o` is 1 and `rst_n_o` is 0.
- R2: If `supply_ok_i` stays low for SUP_N consecutive cycles (the supply filter length in cycles), reset is asserted SUP_N+3 clock edges after the input fell.
- R3: A high-to-low transition on `rstpin_i` asserts reset on the third clock edge after the transition.
- R4: Once started by a pin edge, reset lasts exactly HOLD cycles (the hold time in cycles), even when the external low pulse is shorter.
- R5: Reset stays asserted while `btn_n_i` is low. Reset is released HOLD+3 clock edges after `btn_n_i` returns high.
- R6: A low pulse on `btn_n_i` that is shorter than BTN_N cycles (the button filter length) has no effect on the outputs.
- R7: A low pulse on `supply_ok_i` that is shorter than SUP_N cycles has no effect on the outputs.
- R8: A low level on the pin while the block is itself driving reset does not lengthen the hold time.
- R9: A level cause that arrives while the hold timer is running restarts the timer. Release then comes HOLD+3 edges after that cause ends.
- R10: `rst_n_o` is always the inverse of `rst_drive_o`.
- R11: When `supply_ok_i` first rises, reset is released HOLD+3 clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous clear of the block's flops, active low |
| supply_ok_i | input | 1 | Supply-good comparator flag, asynchronous |
| btn_n_i | input | 1 | Pushbutton input, active low, asynchronous |
| rstpin_i | input | 1 | Level sensed on the shared reset pin, asynchronous |
| rst_drive_o | output | 1 | 1 makes the pad pull the reset pin low |
| rst_n_o | output | 1 | System reset, active low |

## Verification
The assertions assume that `rstpin_i` follows the open-drain wiring. The pin reads low whenever `rst_drive_o` is 1 or an external device pulls it low. The bench builds the pin as that AND of its own external driver and the block's drive. The assertions also assume that `arst_n` is used only once, at start-up. The bench releases it a single time. It changes every asynchronous input on the falling clock edge, so the synchroniser latency is a fixed number of edges and the exact-cycle checks stay valid.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  // Bit positions of the sources inside the synchroniser vector
  typedef enum int unsigned {
    SRC_SUPPLY = 0,
    SRC_BTN    = 1,
    SRC_PIN    = 2
  } src_idx_e;

  localparam int unsigned NUM_SRC = 3;

  // Convert a duration in ns to clock cycles, rounding up, never below one
  function automatic int unsigned ns_to_cycles(int unsigned khz, int unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(khz) * longint'(ns);
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  // Convert a duration in ms to clock cycles, never below two
  function automatic int unsigned ms_to_cycles(int unsigned khz, int unsigned ms);
    longint unsigned cyc;
    cyc = longint'(khz) * longint'(ms);
    if (cyc < 2) cyc = 2;
    return int'(cyc);
  endfunction

  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int unsigned     W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

endmodule

// File: rtl/rstsup_lowfilt.sv
module rstsup_lowfilt #(
  parameter int unsigned N       = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic in_i,
  output logic out_o
);
  import rstsup_pkg::*;

  localparam int unsigned   CW   = cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] run_q;
  logic          out_q;

  // Output rises at once; it falls only after N consecutive low samples
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q <= '0;
      out_q <= RST_VAL;
    end else if (in_i) begin
      run_q <= '0;
      out_q <= 1'b1;
    end else if (run_q == LAST) begin
      out_q <= 1'b0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign out_o = out_q;

  AST_FILT_FULL_RUN: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(out_q) |-> ($past(run_q) == LAST && !$past(in_i))); // R6

  AST_FILT_RUN_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    run_q <= LAST); // R7

endmodule

// File: rtl/rstsup_edge.sv
module rstsup_edge (
  input  logic clk,
  input  logic arst_n,
  input  logic lvl_i,
  input  logic mask_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  // A falling edge is reported only while the block is not driving the pin
  assign fall_o = prev_q & ~lvl_i & ~mask_i;

endmodule

// File: rtl/rstsup_hold.sv
module rstsup_hold #(
  parameter int unsigned HOLD = 40
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_i,
  input  logic kick_i,
  output logic busy_o
);
  import rstsup_pkg::*;

  localparam int unsigned   CW   = cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (hold_i || kick_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST)); // R4

  AST_CAUSE_RESTARTS: assert property (@(posedge clk) disable iff (!arst_n)
    (hold_i || kick_i) |=> (busy_q && cnt_q == '0)); // R9

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    !busy_q |-> cnt_q == '0); // R4

endmodule

// File: rtl/rstgen_supervisor.sv
module rstgen_supervisor #(
  parameter int unsigned CLK_KHZ    = 50_000,
  parameter int unsigned HOLD_MS    = 200,
  parameter int unsigned BTN_NS     = 100,
  parameter int unsigned SUP_NS     = 1_000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok_i,
  input  logic btn_n_i,
  input  logic rstpin_i,
  output logic rst_drive_o,
  output logic rst_n_o
);
  import rstsup_pkg::*;

  localparam int unsigned HOLD_CYC = ms_to_cycles(CLK_KHZ, HOLD_MS);
  localparam int unsigned BTN_CYC  = ns_to_cycles(CLK_KHZ, BTN_NS);
  localparam int unsigned SUP_CYC  = ns_to_cycles(CLK_KHZ, SUP_NS);

  // Supply starts bad; button and pin start released
  localparam logic [NUM_SRC-1:0] SYNC_RST =
    (NUM_SRC'(1) << SRC_BTN) | (NUM_SRC'(1) << SRC_PIN);

  logic [NUM_SRC-1:0] raw_in;
  logic [NUM_SRC-1:0] syn;
  logic               sup_ok_f;
  logic               btn_n_f;
  logic               pin_fall;
  logic               level_cause;
  logic               busy;

  assign raw_in[SRC_SUPPLY] = supply_ok_i;
  assign raw_in[SRC_BTN]    = btn_n_i;
  assign raw_in[SRC_PIN]    = rstpin_i;

  rstsup_sync #(
    .W       (NUM_SRC),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .async_i (raw_in),
    .sync_o  (syn)
  );

  rstsup_lowfilt #(
    .N       (SUP_CYC),
    .RST_VAL (1'b0)
  ) u_sup_filt (
    .clk    (clk),
    .arst_n (arst_n),
    .in_i   (syn[SRC_SUPPLY]),
    .out_o  (sup_ok_f)
  );

  rstsup_lowfilt #(
    .N       (BTN_CYC),
    .RST_VAL (1'b1)
  ) u_btn_filt (
    .clk    (clk),
    .arst_n (arst_n),
    .in_i   (syn[SRC_BTN]),
    .out_o  (btn_n_f)
  );

  rstsup_edge u_pin_edge (
    .clk    (clk),
    .arst_n (arst_n),
    .lvl_i  (syn[SRC_PIN]),
    .mask_i (busy),
    .fall_o (pin_fall)
  );

  assign level_cause = ~sup_ok_f | ~btn_n_f;

  rstsup_hold #(
    .HOLD (HOLD_CYC)
  ) u_hold (
    .clk    (clk),
    .arst_n (arst_n),
    .hold_i (level_cause),
    .kick_i (pin_fall),
    .busy_o (busy)
  );

  assign rst_drive_o = busy;
  assign rst_n_o     = ~busy;

  AST_SUPPLY_LOSS_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_ok_f |=> rst_drive_o); // R2

  AST_BUTTON_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !btn_n_f |=> rst_drive_o); // R5

  AST_PIN_EDGE_STARTS: assert property (@(posedge clk) disable iff (!arst_n)
    pin_fall |=> rst_drive_o); // R3

  AST_OWN_DRIVE_MASKED: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_drive_o && !level_cause) |=> !($past(pin_fall))); // R8

  AST_OUT_PAIR: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n_o != rst_drive_o); // R10

endmodule

// File: tb/test_rstgen_supervisor.sv
module test_rstgen_supervisor;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned HOLD = 40;
  localparam int unsigned BN   = 4;
  localparam int unsigned SN   = 3;
  localparam int unsigned LREL = HOLD + 3;

  logic clk = 1'b0;
  logic arst_n;
  logic supply_ok;
  logic btn_n;
  logic ext_pin_n;
  logic rst_drive;
  logic rst_n;
  logic rstpin;

  int checks = 0;
  int fails  = 0;
  int pair_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Open-drain pin: low when either side pulls it
  assign rstpin = ext_pin_n & ~rst_drive;

  rstgen_supervisor #(
    .CLK_KHZ (1),
    .HOLD_MS (40),
    .BTN_NS  (4_000_000),
    .SUP_NS  (3_000_000)
  ) i_rstgen_supervisor (
    .clk         (clk),
    .arst_n      (arst_n),
    .supply_ok_i (supply_ok),
    .btn_n_i     (btn_n),
    .rstpin_i    (rstpin),
    .rst_drive_o (rst_drive),
    .rst_n_o     (rst_n)
  );

  always @(negedge clk) if (rst_n === rst_drive) pair_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Count cycles in which reset is asserted during a window
  task automatic watch_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      adv(1);
      if (rst_n !== 1'b1) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    arst_n = 1'b0; supply_ok = 1'b0; btn_n = 1'b1; ext_pin_n = 1'b1;
    adv(2);
    chk(rst_drive === 1'b1 && rst_n === 1'b0, "R1 during arst", rst_n, 0);
    arst_n = 1'b1;
    adv(10);
    chk(rst_n === 1'b0, "R1 supply low after arst", rst_n, 0);
  endtask

  task automatic t_powerup();
    supply_ok = 1'b1;
    adv(LREL - 1);
    chk(rst_n === 1'b0, "R11 still held", rst_n, 0);
    adv(1);
    chk(rst_n === 1'b1, "R11 released", rst_n, 1);
  endtask

  task automatic t_btn_glitch();
    btn_n = 1'b0;
    adv(BN - 1);
    btn_n = 1'b1;
    watch_quiet(20, "R6 short button pulse");
  endtask

  task automatic t_btn_hold();
    btn_n = 1'b0;
    adv(BN + 2);
    chk(rst_n === 1'b1, "R5 before filter done", rst_n, 1);
    adv(1);
    chk(rst_n === 1'b0, "R5 asserted", rst_n, 0);
    adv(60);
    chk(rst_n === 1'b0, "R5 held while low", rst_n, 0);
    btn_n = 1'b1;
    adv(LREL - 1);
    chk(rst_n === 1'b0, "R5 hold after release", rst_n, 0);
    adv(1);
    chk(rst_n === 1'b1, "R5 released", rst_n, 1);
    adv(10);
  endtask

  task automatic t_pin_short();
    ext_pin_n = 1'b0;
    adv(2);
    ext_pin_n = 1'b1;
    chk(rst_n === 1'b1, "R3 not before third edge", rst_n, 1);
    adv(1);
    chk(rst_n === 1'b0, "R3 asserted on third edge", rst_n, 0);
    adv(HOLD - 1);
    chk(rst_n === 1'b0, "R4 full hold", rst_n, 0);
    adv(1);
    chk(rst_n === 1'b1, "R4 released after HOLD", rst_n, 1);
    watch_quiet(10, "R4 no retrigger from own drive");
  endtask

  task automatic t_pin_masked();
    ext_pin_n = 1'b0;
    adv(1);
    ext_pin_n = 1'b1;
    adv(10);
    ext_pin_n = 1'b0;
    adv(8);
    ext_pin_n = 1'b1;
    adv(3 + HOLD - 1 - 19);
    chk(rst_n === 1'b0, "R8 still held", rst_n, 0);
    adv(1);
    chk(rst_n === 1'b1, "R8 not extended", rst_n, 1);
    adv(10);
  endtask

  task automatic t_restart();
    ext_pin_n = 1'b0;
    adv(1);
    ext_pin_n = 1'b1;
    adv(20);
    btn_n = 1'b0;
    adv(BN + 5);
    btn_n = 1'b1;
    adv(LREL - 1);
    chk(rst_n === 1'b0, "R9 restarted timer holds", rst_n, 0);
    adv(1);
    chk(rst_n === 1'b1, "R9 release after restart", rst_n, 1);
    adv(10);
  endtask

  task automatic t_sup_glitch();
    supply_ok = 1'b0;
    adv(SN - 1);
    supply_ok = 1'b1;
    watch_quiet(15, "R7 short supply dip");
  endtask

  task automatic t_sup_loss();
    supply_ok = 1'b0;
    adv(SN + 2);
    chk(rst_n === 1'b1, "R2 not before filter", rst_n, 1);
    adv(1);
    chk(rst_n === 1'b0, "R2 asserted", rst_n, 0);
    adv(20);
    supply_ok = 1'b1;
    adv(LREL - 1);
    chk(rst_n === 1'b0, "R11 hold after return", rst_n, 0);
    adv(1);
    chk(rst_n === 1'b1, "R11 released after return", rst_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_powerup();
    t_btn_glitch();
    t_btn_hold();
    t_pin_short();
    t_pin_masked();
    t_restart();
    t_sup_glitch();
    t_sup_loss();
    chk(pair_bad == 0, "R10 outputs inverse", pair_bad, 0);
    summary();
    $finish;
  end

endmodule